// File: doc/BRIEF.md
# Burst-of-Four Separate-Port SRAM Model

This block is a synthesizable behavioural model of a double-data-rate static memory. It has one write port and one read port, and the two ports work independently. Every access moves a fixed group of four 18-bit words. A single clock runs at the beat rate, so each clock edge is one data beat. An internal phase bit splits the beats into whole-cycle edges (phase 0) and half-cycle edges (phase 1). The phase bit is brought out so the surrounding logic can line up its requests. Requests are sampled on phase-0 edges only. Write data is taken over the next two cycles. Read data comes back one and a half cycles after the address is captured.

The block is intended for system-level models and for controller benches that need a memory with the real burst timing, the real request-rejection rule and per-beat byte-lane masking, without pad timing. The storage is a register array that is cleared at reset. There is no tri-state. Outside a read burst the read data bus is held at zero, and `rd_valid` marks each beat that carries a word.

The port interface has no back-pressure. `rd_valid` acts as a valid with no ready: the consumer must take every flagged word on the beat it is presented. The writer must present each write beat on its fixed edge. Requests carry no ready either: a request that breaks the spacing rule is dropped without any notice.

Top module: `qdr_burst_sram`

## Requirements
- R1: After reset `rd_valid` is low, `rd_data` is zero and every stored word reads back as zero.
- R2: `phase` is 0 on the first edge after reset and alternates on every edge. `wr_sel_n` and `rd_sel_n` are acted on only at edges where `phase` is 0. A select held low at a phase-1 edge has no effect.
- R3: A write accepted at phase-0 edge E takes `wr_data` for burst offsets 0, 1, 2 and 3 at edges E+2, E+3, E+4 and E+5.
- R4: A read accepted at phase-0 edge E presents the words for offsets 0 to 3 after edges E+3 to E+6. `rd_valid` is high exactly on those beats, so every run of `rd_valid` is a multiple of four beats long.
- R5: The word at burst offset k has address {A[ADDR_W-1:2], A[1:0]+k}. Only the two low bits count, and they wrap inside the aligned group of four.
- R6: A select is ignored at a phase-0 edge if the same port accepted a request at the previous phase-0 edge. The ignored request writes nothing and produces no read beats.
- R7: On each write beat, `wr_be_n[0]` low stores bits [8:0] and `wr_be_n[1]` low stores bits [17:9]. A lane whose enable bit is 1 keeps its old contents, and a beat with both enable bits at 1 stores nothing. The enables may differ from beat to beat.
- R8: With both selects high and no burst in progress, `wr_data` and `wr_be_n` change nothing, `rd_valid` stays low and `rd_data` stays zero.
- R9: A read beat that addresses the word being written on that same edge returns the value stored before that write.
- R10: A request at the phase-0 edge two phase-0 edges after an accepted request on the same port is accepted. Back-to-back reads accepted this way give eight contiguous valid beats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Beat-rate clock; every rising edge is one data beat |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase | output | 1 | Phase of the coming edge: 0 = whole-cycle edge, 1 = half-cycle edge |
| wr_sel_n | input | 1 | Active-low write request, sampled at phase-0 edges |
| wr_addr | input | ADDR_W | Write burst start address |
| wr_be_n | input | LANES | Active-low lane enables for the current write beat |
| wr_data | input | LANES*LANE_W | Write data for the current beat |
| rd_sel_n | input | 1 | Active-low read request, sampled at phase-0 edges |
| rd_addr | input | ADDR_W | Read burst start address |
| rd_data | output | LANES*LANE_W | Read word; zero when `rd_valid` is low |
| rd_valid | output | 1 | High on each beat that carries a read word |

## Verification
The main function is exercised with several kinds of traffic:
- A burst that starts mid-group separates correct offset wrapping from linear address counting.
- A burst read back from its group base separates beat ordering from address ordering.
- Lane enables that change on every beat show whether masking is applied per beat or held from the first beat.
- Requests placed one phase-0 edge after an accepted one are contrasted with requests placed two edges after it. This tells dropping apart from queueing, and it tells the rejection window apart from a permanent lockout.
- A read offset by one word from a concurrent write lands on the written word at the same edge. It therefore tells a read-before-write array apart from a write-through one.
- Selects held low only at half-cycle edges show that sampling is restricted to whole-cycle edges.

// File: rtl/qsram_pkg.sv
package qsram_pkg;

  typedef enum logic {
    PH_RISE = 1'b0,
    PH_FALL = 1'b1
  } phase_e;

  localparam int BURST_LEN = 4;
  localparam int BEAT_W    = $clog2(BURST_LEN);

endpackage

// File: rtl/qsram_gate.sv
// Request gate: samples an active-low select on whole-cycle edges, drops a
// request that follows an accepted one on the very next whole-cycle edge,
// and fires a start pulse DLY edges after acceptance.
module qsram_gate
  import qsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DLY    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            ph,
  input  logic              sel_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              start,
  output logic [ADDR_W-1:0] start_addr
);

  localparam int CNT_W = $clog2(DLY + 1);

  logic              prev_acc;
  logic              take;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] hold;

  assign take = (ph == PH_RISE) && !sel_n && !prev_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_acc <= 1'b0;
      cnt      <= '0;
      hold     <= '0;
    end else begin
      if (ph == PH_RISE) begin
        prev_acc <= take;
      end
      if (take) begin
        hold <= addr;
        cnt  <= CNT_W'(DLY);
      end else if (cnt != '0) begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  assign start      = (cnt == CNT_W'(1));
  assign start_addr = hold;

endmodule

// File: rtl/qsram_burst.sv
// Burst sequencer: four consecutive beats starting at the start pulse, the
// offset wrapping within the aligned group of four.
module qsram_burst
  import qsram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              beat_vld,
  output logic [ADDR_W-1:0] beat_addr
);

  logic [ADDR_W-1:0] base;
  logic [BEAT_W-1:0] idx;
  logic              act;
  logic [ADDR_W-1:0] cur_base;
  logic [BEAT_W-1:0] cur_idx;
  logic [BEAT_W-1:0] low;

  assign beat_vld  = start | act;
  assign cur_base  = start ? start_addr : base;
  assign cur_idx   = start ? '0 : idx;
  assign low       = cur_base[BEAT_W-1:0] + cur_idx;
  assign beat_addr = {cur_base[ADDR_W-1:BEAT_W], low};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base <= '0;
      idx  <= '0;
      act  <= 1'b0;
    end else if (start) begin
      base <= start_addr;
      idx  <= BEAT_W'(1);
      act  <= 1'b1;
    end else if (act) begin
      idx <= idx + BEAT_W'(1);
      if (idx == BEAT_W'(BURST_LEN - 1)) begin
        act <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/qsram_array.sv
// Storage: one array per byte lane, lane-masked writes, registered
// read-before-write output that is zero when no read beat is present.
module qsram_array #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        wr_lane,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data,
  output logic                    rd_valid
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) begin
          mem[i] <= '0;
        end
        q <= '0;
      end else begin
        if (wr_en && wr_lane[l]) begin
          mem[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
        end
        q <= rd_en ? mem[rd_addr] : '0;
      end
    end

    assign rd_data[l*LANE_W +: LANE_W] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
    end
  end

endmodule

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram
  import qsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  output logic                    phase,
  input  logic                    wr_sel_n,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        wr_be_n,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic                    rd_sel_n,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data,
  output logic                    rd_valid
);

  localparam int DATA_W = LANES * LANE_W;
  localparam int WR_DLY = 2;   // first write beat two edges after capture
  localparam int RD_DLY = 3;   // first read word after the third edge

  phase_e ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_RISE;
    end else begin
      ph <= (ph == PH_RISE) ? PH_FALL : PH_RISE;
    end
  end

  assign phase = ph;

  logic              wr_start, rd_start;
  logic [ADDR_W-1:0] wr_start_addr, rd_start_addr;
  logic              wr_beat, rd_beat;
  logic [ADDR_W-1:0] wr_beat_addr, rd_beat_addr;

  qsram_gate #(.ADDR_W(ADDR_W), .DLY(WR_DLY)) u_wr_gate (
    .clk(clk), .rst_n(rst_n), .ph(ph), .sel_n(wr_sel_n), .addr(wr_addr),
    .start(wr_start), .start_addr(wr_start_addr)
  );

  qsram_gate #(.ADDR_W(ADDR_W), .DLY(RD_DLY)) u_rd_gate (
    .clk(clk), .rst_n(rst_n), .ph(ph), .sel_n(rd_sel_n), .addr(rd_addr),
    .start(rd_start), .start_addr(rd_start_addr)
  );

  qsram_burst #(.ADDR_W(ADDR_W)) u_wr_burst (
    .clk(clk), .rst_n(rst_n), .start(wr_start), .start_addr(wr_start_addr),
    .beat_vld(wr_beat), .beat_addr(wr_beat_addr)
  );

  qsram_burst #(.ADDR_W(ADDR_W)) u_rd_burst (
    .clk(clk), .rst_n(rst_n), .start(rd_start), .start_addr(rd_start_addr),
    .beat_vld(rd_beat), .beat_addr(rd_beat_addr)
  );

  logic [LANES-1:0]  wr_lane;
  logic [DATA_W-1:0] rd_word;
  logic              rd_flag;

  assign wr_lane = ~wr_be_n;

  qsram_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_beat), .wr_addr(wr_beat_addr), .wr_lane(wr_lane), .wr_data(wr_data),
    .rd_en(rd_beat), .rd_addr(rd_beat_addr),
    .rd_data(rd_word), .rd_valid(rd_flag)
  );

  assign rd_data  = rd_word;
  assign rd_valid = rd_flag;

endmodule

// File: rtl/qsram_chk.sv
module qsram_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              phase,
  input logic              rd_sel_n,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data
);

  logic [1:0] vcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcnt <= '0;
    end else begin
      vcnt <= rd_valid ? vcnt + 2'd1 : 2'd0;
    end
  end

  AST_PHASE_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (phase != $past(phase)));                              // R2

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == '0));                                 // R8

  AST_QUAD_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_valid) |-> (vcnt == 2'd0));                            // R4

  AST_FIRST_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> (phase == 1'b0));                           // R4

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> ($past(rd_sel_n, 4) == 1'b0));              // R4

endmodule

bind qdr_burst_sram qsram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .rd_sel_n(rd_sel_n),
  .rd_valid(rd_valid), .rd_data(rd_data)
);

// File: tb/qdr_burst_sram_tb.sv
module qdr_burst_sram_tb;

  localparam int ADDR_W = 6;
  localparam int LANE_W = 9;
  localparam int LANES  = 2;
  localparam int DW     = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              phase;
  logic              wr_sel_n, rd_sel_n;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [LANES-1:0]  wr_be_n;
  logic [DW-1:0]     wr_data, rd_data;
  logic              rd_valid;

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] shadow [DEPTH];

  always #2 clk = ~clk;

  qdr_burst_sram #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_dut (
    .clk(clk), .rst_n(rst_n), .phase(phase),
    .wr_sel_n(wr_sel_n), .wr_addr(wr_addr), .wr_be_n(wr_be_n), .wr_data(wr_data),
    .rd_sel_n(rd_sel_n), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  function automatic logic [ADDR_W-1:0] ba(input logic [ADDR_W-1:0] a, input int k);
    return {a[ADDR_W-1:2], a[1:0] + 2'(k)};
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic exp_rd(input string tag, input logic v, input logic [DW-1:0] d);
    chk({tag, " valid"}, DW'(rd_valid), DW'(v));
    chk({tag, " data"}, rd_data, v ? d : '0);
  endtask

  task automatic idle_in();
    wr_sel_n = 1'b1; rd_sel_n = 1'b1; wr_be_n = '1;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic align0();
    while (phase !== 1'b0) step();
  endtask

  task automatic shadow_wr(input logic [ADDR_W-1:0] a, input logic [DW-1:0] d,
                           input logic [LANES-1:0] be_n);
    if (!be_n[0]) shadow[a][8:0]  = d[8:0];
    if (!be_n[1]) shadow[a][17:9] = d[17:9];
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DW-1:0] d [4],
                          input logic [1:0] be [4]);
    align0();
    for (int e = 0; e < 6; e++) begin
      wr_sel_n = (e == 0) ? 1'b0 : 1'b1;
      wr_addr  = a;
      if (e >= 2) begin
        wr_data = d[e-2]; wr_be_n = be[e-2];
      end else begin
        wr_be_n = 2'b11;
      end
      step();
    end
    idle_in();
    for (int k = 0; k < 4; k++) shadow_wr(ba(a, k), d[k], be[k]);
  endtask

  task automatic do_read(input string tag, input logic [ADDR_W-1:0] a);
    align0();
    for (int e = 0; e < 8; e++) begin
      rd_sel_n = (e == 0) ? 1'b0 : 1'b1;
      rd_addr  = a;
      step();
      if (e >= 3 && e <= 6) exp_rd(tag, 1'b1, shadow[ba(a, e-3)]);
      else                  exp_rd(tag, 1'b0, '0);
    end
    idle_in();
  endtask

  task automatic t_reset();
    chk("R1 valid after reset", DW'(rd_valid), '0);
    chk("R1 data after reset", rd_data, '0);
    chk("R2 phase after reset", DW'(phase), '0);
    step();
    chk("R2 phase toggles", DW'(phase), DW'(1));
    step();
    chk("R2 phase toggles back", DW'(phase), '0);
    do_read("R1 cleared array", 6'd12);
  endtask

  task automatic t_basic();
    logic [DW-1:0] d [4];
    logic [1:0]    be [4];
    d  = '{18'h1A5A5, 18'h05A5A, 18'h3C3C3, 18'h00F0F};
    be = '{2'b00, 2'b00, 2'b00, 2'b00};
    do_write(6'd6, d, be);                 // starts mid-group: 6,7,4,5
    do_read("R5 wrap from 6", 6'd6);
    do_read("R3 order from 4", 6'd4);
  endtask

  task automatic t_lanes();
    logic [DW-1:0] d [4];
    logic [1:0]    be [4];
    d  = '{18'h2AAAA, 18'h15555, 18'h2AAAA, 18'h15555};
    be = '{2'b00, 2'b00, 2'b00, 2'b00};
    do_write(6'd16, d, be);
    d  = '{18'h3FFFF, 18'h3FFFF, 18'h3FFFF, 18'h3FFFF};
    be = '{2'b00, 2'b10, 2'b01, 2'b11};    // per-beat lane masks
    do_write(6'd16, d, be);
    do_read("R7 lane masks", 6'd16);
  endtask

  task automatic t_wr_reject();
    align0();
    for (int e = 0; e < 10; e++) begin
      wr_sel_n = (e == 0 || e == 2) ? 1'b0 : 1'b1;
      wr_addr  = (e == 0) ? 6'd8 : 6'd32;
      wr_data  = 18'h01000 + DW'(e);
      wr_be_n  = (e >= 2) ? 2'b00 : 2'b11;
      step();
      if (e >= 2 && e <= 5) shadow_wr(ba(6'd8, e-2), 18'h01000 + DW'(e), 2'b00);
    end
    idle_in();
    do_read("R6 dropped write", 6'd32);
    do_read("R3 accepted write", 6'd8);
  endtask

  task automatic t_rd_reject();
    align0();
    for (int e = 0; e < 12; e++) begin
      rd_sel_n = (e == 0 || e == 2) ? 1'b0 : 1'b1;
      rd_addr  = (e == 0) ? 6'd6 : 6'd8;
      step();
      if (e >= 3 && e <= 6) exp_rd("R6 dropped read", 1'b1, shadow[ba(6'd6, e-3)]);
      else                  exp_rd("R6 dropped read", 1'b0, '0);
    end
    idle_in();
  endtask

  task automatic t_stream();
    align0();
    for (int e = 0; e < 10; e++) begin
      wr_sel_n = (e == 0 || e == 4) ? 1'b0 : 1'b1;
      wr_addr  = (e == 0) ? 6'd40 : 6'd44;
      wr_data  = 18'h20300 + DW'(e * 7);
      wr_be_n  = (e >= 2) ? 2'b00 : 2'b11;
      step();
      if (e >= 2 && e <= 5) shadow_wr(ba(6'd40, e-2), 18'h20300 + DW'(e * 7), 2'b00);
      if (e >= 6)           shadow_wr(ba(6'd44, e-6), 18'h20300 + DW'(e * 7), 2'b00);
    end
    idle_in();
    align0();
    for (int e = 0; e < 12; e++) begin
      rd_sel_n = (e == 0 || e == 4) ? 1'b0 : 1'b1;
      rd_addr  = (e == 0) ? 6'd40 : 6'd44;
      step();
      if (e >= 3 && e <= 6)       exp_rd("R10 stream first", 1'b1, shadow[ba(6'd40, e-3)]);
      else if (e >= 7 && e <= 10) exp_rd("R10 stream second", 1'b1, shadow[ba(6'd44, e-7)]);
      else                        exp_rd("R10 stream gap", 1'b0, '0);
    end
    idle_in();
  endtask

  task automatic t_nop();
    align0();
    for (int e = 0; e < 8; e++) begin
      wr_data = 18'h3FFFF; wr_be_n = 2'b00; wr_addr = 6'd40; rd_addr = 6'd40;
      step();
      exp_rd("R8 idle", 1'b0, '0);
    end
    align0();
    for (int e = 0; e < 10; e++) begin
      wr_sel_n = (e == 1) ? 1'b0 : 1'b1;   // low only at a half-cycle edge
      rd_sel_n = (e == 1) ? 1'b0 : 1'b1;
      wr_addr  = 6'd48; rd_addr = 6'd48;
      wr_data  = 18'h2BEEF; wr_be_n = 2'b00;
      step();
      exp_rd("R2 half-cycle select", 1'b0, '0);
    end
    idle_in();
    do_read("R2 no write at half-cycle", 6'd48);
    do_read("R8 idle data ignored", 6'd40);
  endtask

  task automatic t_collide();
    logic [DW-1:0] d [4];
    logic [1:0]    be [4];
    logic [DW-1:0] old [4];
    logic [DW-1:0] nw [4];
    d  = '{18'h00111, 18'h00222, 18'h00333, 18'h00444};
    be = '{2'b00, 2'b00, 2'b00, 2'b00};
    do_write(6'd24, d, be);
    for (int k = 0; k < 4; k++) old[k] = shadow[6'd24 + 6'(k)];
    nw = '{18'h3A001, 18'h3A002, 18'h3A003, 18'h3A004};
    align0();
    for (int e = 0; e < 8; e++) begin
      wr_sel_n = (e == 0) ? 1'b0 : 1'b1;  wr_addr = 6'd24;
      rd_sel_n = (e == 0) ? 1'b0 : 1'b1;  rd_addr = 6'd25;
      if (e >= 2 && e <= 5) begin
        wr_data = nw[e-2]; wr_be_n = 2'b00;
      end else begin
        wr_be_n = 2'b11;
      end
      step();
      if (e >= 3 && e <= 5) exp_rd("R9 same-edge old value", 1'b1, old[e-2]);
      else if (e == 6)      exp_rd("R9 after write", 1'b1, nw[0]);
      else                  exp_rd("R9 quiet", 1'b0, '0);
    end
    idle_in();
    for (int k = 0; k < 4; k++) shadow[6'd24 + 6'(k)] = nw[k];
    do_read("R9 final contents", 6'd24);
  endtask

  initial begin
    #(4 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) shadow[i] = '0;
    rst_n = 1'b0;
    idle_in();
    wr_addr = '0; rd_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_lanes();
    t_wr_reject();
    t_rd_reject();
    t_stream();
    t_nop();
    t_collide();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule